// File: doc/BRIEF.md
# PCI Configuration Access Port Decoder

This block sits on a host's simple I/O bus and implements the indirect, two-port method of reaching PCI configuration registers. A dword written to the address port at 0CF8h is kept in an internal latch. The latch names a bus, a device, a function and a dword register, and carries an enable flag. A later access to the data window at 0CFCh–0CFFh becomes one configuration read or write request on a downstream request/acknowledge interface. The block holds the I/O bus with a ready signal until that request finishes.

Only exact full-dword accesses at 0CF8h reach the latch. Narrower accesses there go out unchanged on the ordinary I/O pass-through port, as do all other addresses. This includes byte traffic meant for the control byte at 0CF9h. The same happens to data-window accesses while the enable flag is clear. At the data window, the byte offset and the byte enables together form the lane mask of the configuration request. An empty mask produces no request. A request that is never acknowledged is ended by a timeout. A read ended this way returns all ones.

The I/O bus protocol works as follows. The host raises `io_req` and holds the address, the direction, the enables and the write data until `io_ready` pulses high for one cycle. The host then lowers `io_req` for at least one cycle before the next access.

Top module: `pci_cfg_port`

## Requirements
- R1: A write to address 0CF8h with `io_be` = 4'b1111 stores `io_wdata & 32'h80FF_FFFC` in the latch. A read with the same address and enables returns the latch on `io_rdata`. Either access completes with `io_ready` in the first cycle after the one in which the request is first sampled. Latch fields: bit 31 is the enable flag, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function, and bits 7:2 the register index.
- R2: An access at 0CF8h–0CFBh that is not the R1 case is forwarded to the pass-through port with the same address, direction, enables and write data, and it leaves the latch unchanged. This covers 0CF8h with any `io_be` other than 4'b1111 and any access at 0CF9h–0CFBh.
- R3: With the enable flag set, a data-window access (address bits 15:2 equal to those of 0CFCh) with a non-empty lane mask issues exactly one configuration request. `cfg_bus`, `cfg_dev`, `cfg_fn` and `cfg_reg` equal the latch fields, and `cfg_wr` equals `io_wr`.
- R4: The lane mask `cfg_be` is `(io_be << off) & 4'hF`, where `off` = `io_addr[1:0]`. `cfg_wdata` is `io_wdata << (8*off)`. A read answered by `cfg_ack` returns `cfg_rdata >> (8*off)` on `io_rdata`.
- R5: With the enable flag set and an empty lane mask, no configuration request is issued. The access still completes, and a read returns 32'hFFFF_FFFF.
- R6: With the enable flag clear, data-window accesses are forwarded to the pass-through port and issue no configuration request.
- R7: Any other address is forwarded unchanged. `fwd_req` stays high until `fwd_ready`, and a read returns `fwd_rdata`.
- R8: A configuration request without `cfg_ack` stays up for exactly `TIMEOUT_CYCLES` cycles and then completes the access. A read ended this way returns 32'hFFFF_FFFF.
- R9: After reset the latch is zero, so configuration accesses are disabled. `io_ready`, `fwd_req` and `cfg_req` are low.
- R10: Every access gets exactly one single-cycle `io_ready` pulse, and `fwd_req` and `cfg_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O access request, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables, lane 0 at io_addr |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_ready |
| io_ready | output | 1 | One-cycle completion pulse |
| fwd_req | output | 1 | Pass-through request |
| fwd_wr | output | 1 | Pass-through direction |
| fwd_addr | output | 16 | Pass-through address |
| fwd_be | output | 4 | Pass-through byte enables |
| fwd_wdata | output | 32 | Pass-through write data |
| fwd_rdata | input | 32 | Pass-through read data |
| fwd_ready | input | 1 | Pass-through completion |
| cfg_req | output | 1 | Configuration request |
| cfg_wr | output | 1 | Configuration direction |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 6 | Target dword register |
| cfg_be | output | 4 | Lane mask within the register |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Configuration read data |
| cfg_ack | input | 1 | Configuration completion |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 16. This makes an unanswered request expire in a few cycles, so the exact length of the timeout window can be counted on both reads and writes. With that setting, every combination of the 16 byte-enable values, the four data-window offsets and both directions can be driven for several latch settings. All 16 enable values at the address port can also be swept against the latch. The expected masks, the shifted data and the forward/configure routing are all computed arithmetically.

// File: rtl/pci_cfg_port.sv
module pci_cfg_port #(
  parameter int          TIMEOUT_CYCLES = 64,
  parameter logic [15:0] ADDR_PORT      = 16'h0CF8,
  parameter logic [15:0] DATA_PORT      = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_ready,
  output logic        fwd_req,
  output logic        fwd_wr,
  output logic [15:0] fwd_addr,
  output logic [3:0]  fwd_be,
  output logic [31:0] fwd_wdata,
  input  logic [31:0] fwd_rdata,
  input  logic        fwd_ready,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_fn,
  output logic [5:0]  cfg_reg,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_ack
);
  localparam int          CW       = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [31:0] KEEP     = 32'h80FF_FFFC;
  localparam logic [CW-1:0] LAST   = CW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_CFG, S_DONE} state_t;

  state_t        state;
  logic [31:0]   latch;
  logic [CW-1:0] cnt;
  logic [7:0]    lane_w;
  logic [4:0]    sh;
  logic          hit_addr, hit_data;

  assign sh       = {io_addr[1:0], 3'b000};
  assign lane_w   = {4'b0000, io_be} << io_addr[1:0];
  assign hit_addr = (io_addr == ADDR_PORT) && (io_be == 4'hF);
  assign hit_data = (io_addr[15:2] == DATA_PORT[15:2]);

  assign io_ready  = (state == S_DONE);
  assign fwd_req   = (state == S_FWD);
  assign fwd_wr    = io_wr;
  assign fwd_addr  = io_addr;
  assign fwd_be    = io_be;
  assign fwd_wdata = io_wdata;

  assign cfg_req   = (state == S_CFG);
  assign cfg_wr    = io_wr;
  assign cfg_bus   = latch[23:16];
  assign cfg_dev   = latch[15:11];
  assign cfg_fn    = latch[10:8];
  assign cfg_reg   = latch[7:2];
  assign cfg_be    = lane_w[3:0];
  assign cfg_wdata = io_wdata << sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      latch    <= '0;
      cnt      <= '0;
      io_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (io_req) begin
          if (hit_addr) begin
            if (io_wr) latch <= io_wdata & KEEP;
            else       io_rdata <= latch;
            state <= S_DONE;
          end else if (hit_data && latch[31]) begin
            if (lane_w[3:0] == 4'h0) begin
              io_rdata <= '1;
              state    <= S_DONE;
            end else begin
              cnt   <= '0;
              state <= S_CFG;
            end
          end else begin
            state <= S_FWD;
          end
        end
        S_FWD: if (fwd_ready) begin
          io_rdata <= fwd_rdata;
          state    <= S_DONE;
        end
        S_CFG: begin
          if (cfg_ack) begin
            io_rdata <= cfg_rdata >> sh;
            state    <= S_DONE;
          end else if (cnt == LAST) begin
            io_rdata <= '1;
            state    <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_cfg_port_chk.sv
module pci_cfg_port_chk #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_ready,
  input logic       fwd_req,
  input logic       cfg_req,
  input logic [3:0] cfg_be,
  input logic [7:0] cfg_bus,
  input logic [4:0] cfg_dev
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 2);
  logic [CW-1:0] span;

  always_ff @(posedge clk) begin
    if (!rst_n)       span <= '0;
    else if (!cfg_req) span <= '0;
    else              span <= span + 1'b1;
  end

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_req && cfg_req));
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready);
  p_fwd_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_req) |-> io_ready);
  p_cfg_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_req) |-> io_ready);
  p_mask_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_be != 4'h0));
  p_timeout_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (span < CW'(TIMEOUT_CYCLES)));
  p_target_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && $past(cfg_req)) |-> ($stable(cfg_bus) && $stable(cfg_dev)));
endmodule

bind pci_cfg_port pci_cfg_port_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_ready(io_ready), .fwd_req(fwd_req),
  .cfg_req(cfg_req), .cfg_be(cfg_be), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev)
);

// File: tb/tb_pci_cfg_port.sv
`timescale 1ns/1ps
module tb_pci_cfg_port;
  localparam int T = 16;

  logic        clk = 0, rst_n = 0;
  logic        io_req = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [3:0]  io_be = 0;
  logic [31:0] io_wdata = 0;
  logic [31:0] io_rdata;
  logic        io_ready;
  logic        fwd_req, fwd_wr;
  logic [15:0] fwd_addr;
  logic [3:0]  fwd_be;
  logic [31:0] fwd_wdata;
  logic [31:0] fwd_rdata = 0;
  logic        fwd_ready = 0;
  logic        cfg_req, cfg_wr;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = 0;
  logic        cfg_ack = 0;

  pci_cfg_port #(.TIMEOUT_CYCLES(T)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  int          fwd_n = 0, cfg_n = 0;
  logic        r_fwd_wr;
  logic [15:0] r_fwd_addr;
  logic [3:0]  r_fwd_be;
  logic [31:0] r_fwd_wdata;
  logic        r_cfg_wr;
  logic [7:0]  r_bus;
  logic [4:0]  r_dev;
  logic [2:0]  r_fn;
  logic [5:0]  r_reg;
  logic [3:0]  r_be;
  logic [31:0] r_wdata;

  function automatic logic [31:0] crd(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {b, 3'b000, d, 5'b00000, f, 2'b00, r} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] frd(logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (cfg_req) begin
      cfg_n++;
      r_cfg_wr = cfg_wr; r_bus = cfg_bus; r_dev = cfg_dev; r_fn = cfg_fn;
      r_reg = cfg_reg; r_be = cfg_be; r_wdata = cfg_wdata;
      if (cfg_dev != 5'd31) begin
        repeat (int'(cfg_reg[1:0])) @(negedge clk);
        cfg_rdata = crd(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
        cfg_ack = 1;
        @(negedge clk);
        cfg_ack = 0;
      end else begin
        while (cfg_req) @(negedge clk);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (fwd_req) begin
      fwd_n++;
      r_fwd_wr = fwd_wr; r_fwd_addr = fwd_addr; r_fwd_be = fwd_be; r_fwd_wdata = fwd_wdata;
      @(negedge clk);
      fwd_rdata = frd(r_fwd_addr);
      fwd_ready = 1;
      @(negedge clk);
      fwd_ready = 0;
    end
  end

  task automatic acc(input logic [15:0] a, input logic w, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    io_addr = a; io_wr = w; io_be = be; io_wdata = wd; io_req = 1;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!io_ready);
    rd = io_rdata;
    io_req = 0;
    @(negedge clk);
  endtask

  task automatic set_latch(input logic [31:0] v);
    logic [31:0] rd; int w;
    acc(16'h0CF8, 1'b1, 4'hF, v, rd, w);
  endtask

  task automatic get_latch(output logic [31:0] v);
    int w;
    acc(16'h0CF8, 1'b0, 4'hF, 32'h0, v, w);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, lv;
    int w, n0, f0;
    repeat (3) @(negedge clk);
    check(io_ready == 0 && cfg_req == 0 && fwd_req == 0, "R9 idle outputs",
          {29'b0, io_ready, cfg_req, fwd_req}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    get_latch(lv);
    check(lv == 32'h0, "R9 latch after reset", lv, 32'h0);
    n0 = cfg_n; f0 = fwd_n;
    acc(16'h0CFC, 1'b0, 4'hF, 32'h0, rd, w);
    check(cfg_n == n0 && fwd_n == f0 + 1, "R9 disabled after reset", cfg_n - n0, 0);

    set_latch(32'hFFFF_FFFF);
    get_latch(lv);
    check(lv == 32'h80FF_FFFC, "R1 masked store", lv, 32'h80FF_FFFC);
    acc(16'h0CF8, 1'b1, 4'hF, 32'h8012_3454, rd, w);
    check(w == 1, "R1 write latency", w, 1);
    acc(16'h0CF8, 1'b0, 4'hF, 32'h0, rd, w);
    check(w == 1 && rd == 32'h8012_3454, "R1 read back", rd, 32'h8012_3454);

    for (int be = 0; be < 15; be++) begin
      f0 = fwd_n; n0 = cfg_n;
      acc(16'h0CF8, 1'b1, 4'(be), 32'h0000_0000, rd, w);
      check(fwd_n == f0 + 1 && cfg_n == n0 && r_fwd_addr == 16'h0CF8 && r_fwd_be == 4'(be)
            && r_fwd_wr == 1'b1 && r_fwd_wdata == 32'h0,
            "R2 narrow at address port forwarded", {12'b0, r_fwd_be, r_fwd_addr}, {12'b0, 4'(be), 16'h0CF8});
      get_latch(lv);
      check(lv == 32'h8012_3454, "R2 latch unchanged", lv, 32'h8012_3454);
    end
    for (int a = 1; a < 4; a++) begin
      for (int wr = 0; wr < 2; wr++) begin
        f0 = fwd_n;
        acc(16'h0CF8 + 16'(a), 1'(wr), 4'h1, 32'h0000_0005, rd, w);
        check(fwd_n == f0 + 1 && r_fwd_addr == 16'h0CF8 + 16'(a) && r_fwd_wr == 1'(wr),
              "R2 control byte forwarded", {16'b0, r_fwd_addr}, {16'b0, 16'h0CF8 + 16'(a)});
        if (!wr) check(rd == frd(16'h0CF8 + 16'(a)), "R2 forwarded read data", rd, frd(16'h0CF8 + 16'(a)));
        get_latch(lv);
        check(lv == 32'h8012_3454, "R2 latch unchanged after control byte", lv, 32'h8012_3454);
      end
    end

    for (int t = 0; t < 3; t++) begin
      logic [7:0] b; logic [4:0] d; logic [2:0] f; logic [5:0] r;
      b = 8'(8'h11 * (t + 1)); d = 5'(7 * t + 3); f = 3'(t * 3 + 1); r = 6'(t * 21 + 2);
      set_latch({1'b1, 7'b0, b, d, f, r, 2'b00});
      for (int off = 0; off < 4; off++) begin
        for (int be = 0; be < 16; be++) begin
          for (int wr = 0; wr < 2; wr++) begin
            logic [7:0] m8; logic [3:0] m; logic [31:0] wd, er;
            m8 = 8'(be) << off; m = m8[3:0];
            wd = 32'hC3A5_0F96 ^ 32'(be * 32'h0101_0101);
            n0 = cfg_n; f0 = fwd_n;
            acc(16'h0CFC + 16'(off), 1'(wr), 4'(be), wd, rd, w);
            if (m == 4'h0) begin
              check(cfg_n == n0 && fwd_n == f0, "R5 empty mask no request", cfg_n - n0, 0);
              if (!wr) check(rd == 32'hFFFF_FFFF, "R5 empty mask read", rd, 32'hFFFF_FFFF);
            end else begin
              check(cfg_n == n0 + 1 && fwd_n == f0, "R3 one request", cfg_n - n0, 1);
              check(r_bus == b && r_dev == d && r_fn == f && r_reg == r && r_cfg_wr == 1'(wr),
                    "R3 target fields", {r_cfg_wr, 5'b0, r_bus, r_dev, r_fn, r_reg, 4'b0},
                    {1'(wr), 5'b0, b, d, f, r, 4'b0});
              check(r_be == m, "R4 lane mask", {28'b0, r_be}, {28'b0, m});
              if (wr) check(r_wdata == (wd << (8 * off)), "R4 write data lanes", r_wdata, wd << (8 * off));
              else begin
                er = crd(b, d, f, r) >> (8 * off);
                check(rd == er, "R4 read data lanes", rd, er);
              end
            end
          end
        end
      end
    end

    set_latch({1'b1, 7'b0, 8'h42, 5'd31, 3'd2, 6'd9, 2'b00});
    acc(16'h0CFC, 1'b0, 4'hF, 32'h0, rd, w);
    check(rd == 32'hFFFF_FFFF, "R8 timeout read all ones", rd, 32'hFFFF_FFFF);
    check(w == T + 1, "R8 timeout length on read", w, T + 1);
    n0 = cfg_n;
    acc(16'h0CFE, 1'b1, 4'h3, 32'h1234, rd, w);
    check(w == T + 1 && cfg_n == n0 + 1, "R8 timeout length on write", w, T + 1);

    set_latch({1'b0, 7'b0, 8'h42, 5'd4, 3'd2, 6'd9, 2'b00});
    for (int off = 0; off < 4; off++) begin
      n0 = cfg_n; f0 = fwd_n;
      acc(16'h0CFC + 16'(off), 1'b0, 4'h1, 32'h0, rd, w);
      check(cfg_n == n0 && fwd_n == f0 + 1 && rd == frd(16'h0CFC + 16'(off)),
            "R6 disabled window forwarded", rd, frd(16'h0CFC + 16'(off)));
    end

    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      a = 16'(16'h0080 + k * 16'h0371);
      for (int wr = 0; wr < 2; wr++) begin
        f0 = fwd_n; n0 = cfg_n;
        acc(a, 1'(wr), 4'(k + 3), 32'hA0B0_C0D0 + 32'(k), rd, w);
        check(fwd_n == f0 + 1 && cfg_n == n0 && r_fwd_addr == a && r_fwd_be == 4'(k + 3)
              && r_fwd_wr == 1'(wr) && r_fwd_wdata == 32'hA0B0_C0D0 + 32'(k),
              "R7 other address forwarded unchanged", {16'b0, r_fwd_addr}, {16'b0, a});
        if (!wr) check(rd == frd(a), "R7 forwarded read data", rd, frd(a));
      end
    end

    acc(16'h0CF8, 1'b0, 4'hF, 32'h0, rd, w);
    @(negedge clk);
    check(io_ready == 0, "R10 single ready pulse", {31'b0, io_ready}, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule